// File: doc/BRIEF.md
# Stream Handshake Protocol Checker

This block is a passive observer for one point-to-point stream link built from a payload bus, a strobe from the sender and an acknowledge from the receiver. It samples the link on every rising clock edge and never drives any link signal. It checks that both endpoints follow the handshake rules. A transfer completes on any edge where strobe and acknowledge are both high. Once either endpoint has raised its handshake signal, it must keep it high until a transfer completes. The payload must stay steady while the strobe is waiting. Both handshake signals must be low while the link is held in reset.

Each rule class has its own sticky error flag, and one combined flag covers all of them. A saturating counter reports how many transfers have completed. The monitor has its own asynchronous active-low reset, which clears the flags and the counter. The link's own active-high reset is an observed input, so violations that occur during a link reset can still be recorded. The block is synthesizable and suits on-chip debug as well as simulation.

Top module: `hs_link_monitor`

## Requirements
- R1: While `rst_n` is low, all error flags and `xfer_count` are 0.
- R2: `xfer_count` increases by one after each rising edge where `link_stb` and `link_ack` are both 1 and `link_rst` is 0 on that edge and on the previous edge. Back-to-back transfers are counted once per edge.
- R3: `xfer_count` saturates at its all-ones value (`CNT_W` bits, default 32) and stays there until `rst_n` goes low.
- R4: `err_rst` is set after an edge where `link_rst` was 1 on the previous edge and `link_stb` or `link_ack` is 1. The first edge that samples `link_rst` high does not raise the flag.
- R5: `err_stb_drop` is set after an edge where `link_stb` is 0, `link_stb` was 1 on the previous edge, no transfer completed on the previous edge, and `link_rst` was 0 on the previous edge.
- R6: `err_ack_drop` is set after an edge where `link_ack` is 0, `link_ack` was 1 on the previous edge, no transfer completed on the previous edge, and `link_rst` was 0 on the previous edge.
- R7: `err_data` is set after an edge where `link_stb` is 1 and `link_data` differs from its previous-edge value, `link_stb` was 1 on the previous edge, no transfer completed on the previous edge, and `link_rst` was 0 on the previous edge.
- R8: None of these changes raises a flag: payload changes while `link_stb` is 0, payload changes on the edge after a completed transfer, or an acknowledge that waits for a strobe.
- R9: Each error flag stays set until `rst_n` goes low. `err_any` is the OR of the four individual flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, rising edge sampled |
| rst_n | input | 1 | Monitor reset, asynchronous assert, active low |
| link_rst | input | 1 | Observed link reset, active high |
| link_data | input | DATA_W | Observed payload |
| link_stb | input | 1 | Observed sender strobe |
| link_ack | input | 1 | Observed receiver acknowledge |
| err_rst | output | 1 | Sticky: handshake high during link reset |
| err_stb_drop | output | 1 | Sticky: strobe withdrawn before completion |
| err_ack_drop | output | 1 | Sticky: acknowledge withdrawn before completion |
| err_data | output | 1 | Sticky: payload changed while strobe waited |
| err_any | output | 1 | OR of all sticky flags |
| xfer_count | output | CNT_W | Saturating count of completed transfers |

## Verification
The hardest cases to reach involve the boundaries between rules. One is the edge right after a completed transfer, where a drop or a payload change is legal. The other is the edge that first samples link reset, where the handshake may still be high and must not be flagged. Directed sequences place a drop, a payload change and a link-reset entry exactly on these edges. Seeded random stimulus with a strong bias toward held handshakes then builds long wait states and back-to-back runs. A short counter width in the bench makes saturation reachable.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int ERR_RST  = 0;
  localparam int ERR_STB  = 1;
  localparam int ERR_ACK  = 2;
  localparam int ERR_DATA = 3;
  localparam int ERR_N    = 4;
endpackage

// File: rtl/hs_mon_history.sv
module hs_mon_history #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_rst,
  input  logic [DATA_W-1:0] link_data,
  input  logic              link_stb,
  input  logic              link_ack,
  input  logic              fire,
  output logic              h_rst,
  output logic              h_stb,
  output logic              h_ack,
  output logic              h_fire,
  output logic [DATA_W-1:0] h_data
);
  logic              rst_d, stb_d, ack_d, fire_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    rst_d  = link_rst;
    stb_d  = link_stb;
    ack_d  = link_ack;
    fire_d = fire;
    data_d = link_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rst  <= 1'b0;
      h_stb  <= 1'b0;
      h_ack  <= 1'b0;
      h_fire <= 1'b0;
      h_data <= '0;
    end else begin
      h_rst  <= rst_d;
      h_stb  <= stb_d;
      h_ack  <= ack_d;
      h_fire <= fire_d;
      h_data <= data_d;
    end
  end
endmodule

// File: rtl/hs_mon_rules.sv
module hs_mon_rules
  import hs_mon_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_rst,
  input  logic [DATA_W-1:0] link_data,
  input  logic              link_stb,
  input  logic              link_ack,
  input  logic              h_rst,
  input  logic              h_stb,
  input  logic              h_ack,
  input  logic              h_fire,
  input  logic [DATA_W-1:0] h_data,
  output logic              fire,
  output logic [ERR_N-1:0]  err_q
);
  logic [ERR_N-1:0] viol;
  logic [ERR_N-1:0] err_d;
  logic             pend_stb, pend_ack;

  always_comb begin
    fire     = link_stb & link_ack & ~link_rst & ~h_rst;
    pend_stb = ~h_rst & h_stb & ~h_fire;
    pend_ack = ~h_rst & h_ack & ~h_fire;
    viol           = '0;
    viol[ERR_RST]  = h_rst & (link_stb | link_ack);
    viol[ERR_STB]  = pend_stb & ~link_stb;
    viol[ERR_ACK]  = pend_ack & ~link_ack;
    viol[ERR_DATA] = pend_stb & link_stb & (link_data != h_data);
    err_d          = err_q | viol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  assert_rst_viol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rst && (link_stb || link_ack)) |=> err_q[ERR_RST]);
  assert_stb_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rst && h_stb && !h_fire && !link_stb) |=> err_q[ERR_STB]);
  assert_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rst && h_ack && !h_fire && !link_ack) |=> err_q[ERR_ACK]);
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rst && h_stb && !h_fire && link_stb && link_data != h_data) |=> err_q[ERR_DATA]);
endmodule

// File: rtl/hs_mon_counter.sv
module hs_mon_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_en = fire && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(cnt_q));
  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/hs_link_monitor.sv
module hs_link_monitor
  import hs_mon_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_rst,
  input  logic [DATA_W-1:0] link_data,
  input  logic              link_stb,
  input  logic              link_ack,
  output logic              err_rst,
  output logic              err_stb_drop,
  output logic              err_ack_drop,
  output logic              err_data,
  output logic              err_any,
  output logic [CNT_W-1:0]  xfer_count
);
  logic              fire;
  logic              h_rst, h_stb, h_ack, h_fire;
  logic [DATA_W-1:0] h_data;
  logic [ERR_N-1:0]  err_q;

  hs_mon_history #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .link_rst(link_rst), .link_data(link_data),
    .link_stb(link_stb), .link_ack(link_ack), .fire(fire),
    .h_rst(h_rst), .h_stb(h_stb), .h_ack(h_ack), .h_fire(h_fire), .h_data(h_data)
  );

  hs_mon_rules #(.DATA_W(DATA_W)) u_rules (
    .clk(clk), .rst_n(rst_n), .link_rst(link_rst), .link_data(link_data),
    .link_stb(link_stb), .link_ack(link_ack),
    .h_rst(h_rst), .h_stb(h_stb), .h_ack(h_ack), .h_fire(h_fire), .h_data(h_data),
    .fire(fire), .err_q(err_q)
  );

  hs_mon_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cnt_q(xfer_count)
  );

  always_comb begin
    err_rst      = err_q[ERR_RST];
    err_stb_drop = err_q[ERR_STB];
    err_ack_drop = err_q[ERR_ACK];
    err_data     = err_q[ERR_DATA];
    err_any      = |err_q;
  end

  assert_any_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> err_any);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (!err_any && xfer_count == '0));
endmodule

// File: tb/sim_hs_link_monitor.sv
module sim_hs_link_monitor;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic clk = 1'b0;
  logic rst_n, link_rst, link_stb, link_ack;
  logic [DW-1:0] link_data;
  logic err_rst, err_stb_drop, err_ack_drop, err_data, err_any;
  logic [CW-1:0] xfer_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit m_rq, m_hs, m_ha, m_hf;
  logic [DW-1:0] m_hd;
  bit e_rst, e_stb, e_ack, e_dat;
  int m_cnt;

  always #5 clk = ~clk;

  hs_link_monitor #(.DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .link_rst(link_rst), .link_data(link_data),
    .link_stb(link_stb), .link_ack(link_ack),
    .err_rst(err_rst), .err_stb_drop(err_stb_drop), .err_ack_drop(err_ack_drop),
    .err_data(err_data), .err_any(err_any), .xfer_count(xfer_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int next_count(input int c, input bit f);
    if (f && c < int'(CMAX)) return c + 1;
    return c;
  endfunction

  task automatic model_clear();
    m_rq = 0; m_hs = 0; m_ha = 0; m_hf = 0; m_hd = '0;
    e_rst = 0; e_stb = 0; e_ack = 0; e_dat = 0; m_cnt = 0;
  endtask

  task automatic compare_all();
    chk("R4 err_rst", int'(err_rst), int'(e_rst));
    chk("R5 err_stb_drop", int'(err_stb_drop), int'(e_stb));
    chk("R6 err_ack_drop", int'(err_ack_drop), int'(e_ack));
    chk("R7 err_data", int'(err_data), int'(e_dat));
    chk("R9 err_any", int'(err_any), int'(e_rst | e_stb | e_ack | e_dat));
    chk("R2 xfer_count", int'(xfer_count), m_cnt);
  endtask

  task automatic step(input bit s, input bit a, input logic [DW-1:0] d, input bit lr);
    bit f, pend_s, pend_a;
    @(negedge clk);
    link_stb = s; link_ack = a; link_data = d; link_rst = lr;
    @(posedge clk);
    #1;
    f = s & a & ~lr & ~m_rq;
    pend_s = ~m_rq & m_hs & ~m_hf;
    pend_a = ~m_rq & m_ha & ~m_hf;
    if (m_rq && (s || a)) e_rst = 1;
    if (pend_s && !s) e_stb = 1;
    if (pend_a && !a) e_ack = 1;
    if (pend_s && s && d != m_hd) e_dat = 1;
    m_cnt = next_count(m_cnt, f);
    m_rq = lr; m_hs = s; m_ha = a; m_hf = f; m_hd = d;
    compare_all();
  endtask

  task automatic mon_reset();
    @(negedge clk);
    rst_n = 0;
    link_stb = 0; link_ack = 0; link_rst = 0; link_data = '0;
    #2;
    model_clear();
    chk("R1 flags in reset", int'(err_any), 0);
    chk("R1 count in reset", int'(xfer_count), 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int seed;
    bit s, a, lr;
    logic [DW-1:0] d;
    seed = 17;
    void'($urandom(seed));
    rst_n = 0; link_rst = 0; link_stb = 0; link_ack = 0; link_data = '0;
    model_clear();
    #1;
    mon_reset();

    // R8: payload wanders while strobe low, ack waits for strobe
    step(0, 0, 8'h11, 0); step(0, 0, 8'h22, 0); step(0, 1, 8'h33, 0); step(0, 1, 8'h44, 0);
    step(1, 1, 8'h55, 0);
    chk("R8 no flag on idle data / waiting ack", int'(err_any), 0);
    chk("R2 first transfer", int'(xfer_count), 1);
    // R2: back-to-back, data changes right after each completion (R8)
    step(1, 1, 8'h56, 0); step(1, 1, 8'h57, 0); step(1, 1, 8'h58, 0);
    chk("R2 back-to-back count", int'(xfer_count), 4);
    chk("R8 data change after transfer legal", int'(err_data), 0);
    // sender waits for ack, strobe held
    step(1, 0, 8'h60, 0); step(1, 0, 8'h60, 0); step(1, 1, 8'h60, 0); step(0, 0, 8'h00, 0);
    chk("R2 stb waiting then transfer", int'(xfer_count), 5);
    chk("R5 drop after completion legal", int'(err_stb_drop), 0);

    // R5: strobe withdrawn
    step(1, 0, 8'h70, 0); step(0, 0, 8'h70, 0);
    chk("R5 stb drop", int'(err_stb_drop), 1);
    step(0, 0, 8'h00, 0); step(0, 0, 8'h00, 0);
    chk("R9 sticky", int'(err_stb_drop), 1);
    mon_reset();
    chk("R1 cleared", int'(err_stb_drop), 0);

    // R6: acknowledge withdrawn
    step(0, 1, 8'h00, 0); step(0, 0, 8'h00, 0);
    chk("R6 ack drop", int'(err_ack_drop), 1);
    chk("R9 any", int'(err_any), 1);
    mon_reset();

    // R7: payload changes while stb pending
    step(1, 0, 8'hA0, 0); step(1, 0, 8'hA1, 0);
    chk("R7 data unstable", int'(err_data), 1);
    mon_reset();

    // R4: link reset entry with handshake high is legal, held high is not
    step(1, 1, 8'h01, 1);
    chk("R4 first reset edge legal", int'(err_rst), 0);
    chk("R2 no count during link reset", int'(xfer_count), 0);
    step(0, 0, 8'h00, 1); step(0, 0, 8'h00, 1);
    chk("R4 clean reset", int'(err_rst), 0);
    step(0, 1, 8'h00, 1);
    chk("R4 ack during link reset", int'(err_rst), 1);
    step(0, 0, 8'h00, 0);
    chk("R6 no drop after reset", int'(err_ack_drop), 0);
    mon_reset();

    // R3: saturation
    for (int i = 0; i < 20; i++) step(1, 1, 8'(i), 0);
    chk("R3 saturated", int'(xfer_count), int'(CMAX));
    step(0, 0, 8'h00, 0);
    chk("R3 stays saturated", int'(xfer_count), int'(CMAX));
    mon_reset();

    // random phase, biased toward held handshakes
    s = 0; a = 0; d = '0;
    for (int i = 0; i < 4000; i++) begin
      bit fired;
      if (i % 500 == 499) mon_reset();
      fired = s & a;
      if (!s || fired) s = ($urandom % 3) == 0;
      else if (($urandom % 40) == 0) s = 0;
      if (!a || fired) a = ($urandom % 3) == 0;
      else if (($urandom % 40) == 0) a = 0;
      if (!s || fired || ($urandom % 50) == 0) d = DW'($urandom);
      lr = ($urandom % 60) == 0;
      step(s, a, d, lr);
      if (lr && ($urandom % 2) == 0) begin s = 0; a = 0; end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule